// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Prioritizer

This block collects interrupt requests from external IRQ lines, on-chip module lines, a non-maskable input and an address-break line. It presents the single request that the processor may currently take. Two status bits, a primary block bit and a secondary block bit, set the masking. Each IRQ line also carries a one-bit control level. Level-1 lines stay open while either status bit is clear. Level-0 lines, and every module line, need the primary bit clear. The non-maskable input and the address-break line are never blocked.

The winning request is registered as a vector index with a valid flag, and it is held there until the processor acknowledges it. On acknowledge, the block enters exception state by setting both status bits. It drops the valid flag, and it pulses a one-cycle clear strobe toward the acknowledged IRQ line so that outside edge-detection logic can be cleared. The processor rewrites the status bits through a write strobe.

Top module: `irq_prioritizer`

## Requirements
- R1: During and right after a synchronous active-high reset, `req_valid` and `irq_clr` are 0, `mask_i` is 1, `mask_ui` is 0, and no non-maskable request is pending.
- R2: A level-0 IRQ (its `irq_lvl` bit is 0) and any module request can win only while `mask_i` is 0.
- R3: A level-1 IRQ (its `irq_lvl` bit is 1) can win while `mask_i` is 0 or `mask_ui` is 0, and is blocked only when both are 1.
- R4: A pending non-maskable request and an asserted `brk_req` can win under every mask state.
- R5: An IRQ or module line competes only when its request bit and its enable bit are both 1.
- R6: Priority from highest down: non-maskable, level-1 IRQs by ascending index, address break, level-0 IRQs by ascending index, then modules by ascending index. Vector indices are: non-maskable 0, address break 1, IRQ k is 2+k, module j is 2+N_IRQ+j.
- R7: Request inputs are registered, so a winner appears on `req_valid`/`req_vec` at the second rising edge after the inputs are applied.
- R8: While `req_valid` is 1 and `ack` is 0, `req_valid` and `req_vec` hold their values, even when a higher-priority request arrives.
- R9: `ack` while `req_valid` is 1 sets `mask_i` and `mask_ui` to 1 and clears `req_valid` at the next edge. `ack` without `req_valid` has no effect.
- R10: The non-maskable input is taken on a rising edge and stays pending until its vector is acknowledged. A level that stays high does not raise it again.
- R11: Acknowledging IRQ k drives `irq_clr[k]` high for exactly one cycle. No other bit of `irq_clr` is ever set.
- R12: When `ack` (with `req_valid`) and `stat_wr` fall in the same cycle, the acknowledge wins and both mask bits become 1.
- R13: `stat_wr` without an effective acknowledge loads `mask_i` from `stat_i` and `mask_ui` from `stat_ui` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | N_IRQ | External IRQ request lines (level) |
| irq_en | input | N_IRQ | Per-IRQ enable |
| irq_lvl | input | N_IRQ | Per-IRQ control level (1 = level 1) |
| mod_req | input | N_MOD | On-chip module request lines |
| mod_en | input | N_MOD | Per-module enable |
| brk_req | input | 1 | Address-break request |
| nmi_in | input | 1 | Non-maskable input, rising-edge sensitive |
| ack | input | 1 | Processor acknowledge of the presented request |
| stat_wr | input | 1 | Status write strobe |
| stat_i | input | 1 | Primary block bit value to write |
| stat_ui | input | 1 | Secondary block bit value to write |
| req_valid | output | 1 | A request is presented |
| req_vec | output | VW | Vector index of the presented request |
| mask_i | output | 1 | Current primary block bit |
| mask_ui | output | 1 | Current secondary block bit |
| irq_clr | output | N_IRQ | One-cycle clear strobe for the acknowledged IRQ |

## Verification
Acknowledge and a status write can fall in the same cycle, and so can acknowledge and the re-arbitration that follows it. The sweep drives an acknowledge together with a status write that clears both bits on part of its patterns. It then judges that both bits read 1, that the clear strobe names the acknowledged IRQ, and that on the following edge only the address break can be presented. Hold behaviour is provoked by raising the non-maskable input while a lower request is already presented, and is judged by the vector staying put until acknowledge.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

    typedef struct packed {
        logic i_blk;
        logic ui_blk;
    } mask_t;

    localparam int VEC_NMI  = 0;
    localparam int VEC_BRK  = 1;
    localparam int VEC_IRQ0 = 2;

    // Is a source at the given control level open under the mask?
    function automatic logic lvl_open(input logic lvl, input mask_t m);
        return lvl ? !(m.i_blk && m.ui_blk) : !m.i_blk;
    endfunction

endpackage

// File: rtl/irqp_capture.sv
module irqp_capture #(
    parameter int N_IRQ = 8,
    parameter int N_MOD = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_MOD-1:0] mod_req,
    input  logic [N_MOD-1:0] mod_en,
    input  logic             brk_req,
    input  logic             nmi_in,
    input  logic             nmi_clr,
    output logic [N_IRQ-1:0] irq_act,
    output logic [N_MOD-1:0] mod_act,
    output logic             brk_act,
    output logic             nmi_pend
);
    logic nmi_prev;
    logic nmi_rise;

    assign nmi_rise = nmi_in && !nmi_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_act  <= '0;
            mod_act  <= '0;
            brk_act  <= 1'b0;
            nmi_prev <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            irq_act  <= irq_req & irq_en;
            mod_act  <= mod_req & mod_en;
            brk_act  <= brk_req;
            nmi_prev <= nmi_in;
            nmi_pend <= nmi_rise || (nmi_pend && !nmi_clr);
        end
    end
endmodule

// File: rtl/irqp_arbiter.sv
module irqp_arbiter
    import irqp_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int N_MOD = 8,
    parameter int VW    = 5
) (
    input  logic [N_IRQ-1:0] irq_act,
    input  logic [N_IRQ-1:0] irq_lvl,
    input  logic [N_MOD-1:0] mod_act,
    input  logic             brk_act,
    input  logic             nmi_pend,
    input  mask_t            mask,
    output logic             win,
    output logic [VW-1:0]    win_vec
);
    localparam int MOD_BASE = VEC_IRQ0 + N_IRQ;

    // Tiers are written lowest priority first; later hits overwrite.
    always_comb begin
        win     = 1'b0;
        win_vec = '0;
        for (int j = N_MOD - 1; j >= 0; j--) begin
            if (mod_act[j] && lvl_open(1'b0, mask)) begin
                win     = 1'b1;
                win_vec = VW'(MOD_BASE + j);
            end
        end
        for (int k = N_IRQ - 1; k >= 0; k--) begin
            if (irq_act[k] && !irq_lvl[k] && lvl_open(1'b0, mask)) begin
                win     = 1'b1;
                win_vec = VW'(VEC_IRQ0 + k);
            end
        end
        if (brk_act) begin
            win     = 1'b1;
            win_vec = VW'(VEC_BRK);
        end
        for (int k = N_IRQ - 1; k >= 0; k--) begin
            if (irq_act[k] && irq_lvl[k] && lvl_open(1'b1, mask)) begin
                win     = 1'b1;
                win_vec = VW'(VEC_IRQ0 + k);
            end
        end
        if (nmi_pend) begin
            win     = 1'b1;
            win_vec = VW'(VEC_NMI);
        end
    end
endmodule

// File: rtl/irqp_mask.sv
module irqp_mask
    import irqp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  logic  wr,
    input  mask_t wr_val,
    output mask_t mask
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask.i_blk  <= 1'b1;
            mask.ui_blk <= 1'b0;
        end else if (take) begin
            mask.i_blk  <= 1'b1;
            mask.ui_blk <= 1'b1;
        end else if (wr) begin
            mask <= wr_val;
        end
    end
endmodule

// File: rtl/irq_prioritizer.sv
module irq_prioritizer
    import irqp_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int N_MOD = 8,
    parameter int N_SRC = VEC_IRQ0 + N_IRQ + N_MOD,
    parameter int VW    = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_IRQ-1:0] irq_lvl,
    input  logic [N_MOD-1:0] mod_req,
    input  logic [N_MOD-1:0] mod_en,
    input  logic             brk_req,
    input  logic             nmi_in,
    input  logic             ack,
    input  logic             stat_wr,
    input  logic             stat_i,
    input  logic             stat_ui,
    output logic             req_valid,
    output logic [VW-1:0]    req_vec,
    output logic             mask_i,
    output logic             mask_ui,
    output logic [N_IRQ-1:0] irq_clr
);
    logic [N_IRQ-1:0] irq_act;
    logic [N_MOD-1:0] mod_act;
    logic             brk_act;
    logic             nmi_pend;
    logic             take;
    logic             nmi_clr;
    logic             win;
    logic [VW-1:0]    win_vec;
    mask_t            mask;
    mask_t            wr_val;

    assign take    = ack && req_valid;
    assign nmi_clr = take && (req_vec == VW'(VEC_NMI));
    assign wr_val  = '{i_blk: stat_i, ui_blk: stat_ui};
    assign mask_i  = mask.i_blk;
    assign mask_ui = mask.ui_blk;

    irqp_capture #(.N_IRQ(N_IRQ), .N_MOD(N_MOD)) u_capture (
        .clk(clk), .rst(rst),
        .irq_req(irq_req), .irq_en(irq_en),
        .mod_req(mod_req), .mod_en(mod_en),
        .brk_req(brk_req), .nmi_in(nmi_in), .nmi_clr(nmi_clr),
        .irq_act(irq_act), .mod_act(mod_act),
        .brk_act(brk_act), .nmi_pend(nmi_pend)
    );

    irqp_arbiter #(.N_IRQ(N_IRQ), .N_MOD(N_MOD), .VW(VW)) u_arbiter (
        .irq_act(irq_act), .irq_lvl(irq_lvl), .mod_act(mod_act),
        .brk_act(brk_act), .nmi_pend(nmi_pend), .mask(mask),
        .win(win), .win_vec(win_vec)
    );

    irqp_mask u_mask (
        .clk(clk), .rst(rst), .take(take),
        .wr(stat_wr), .wr_val(wr_val), .mask(mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid <= 1'b0;
            req_vec   <= '0;
            irq_clr   <= '0;
        end else begin
            irq_clr <= '0;
            if (take) begin
                req_valid <= 1'b0;
                for (int k = 0; k < N_IRQ; k++) begin
                    if (req_vec == VW'(VEC_IRQ0 + k)) irq_clr[k] <= 1'b1;
                end
            end else if (!req_valid) begin
                req_valid <= win;
                req_vec   <= win_vec;
            end
        end
    end
endmodule

// File: rtl/irqp_chk.sv
module irqp_chk #(
    parameter int N_IRQ = 8,
    parameter int VW    = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             ack,
    input logic             stat_wr,
    input logic             stat_i,
    input logic             stat_ui,
    input logic             req_valid,
    input logic [VW-1:0]    req_vec,
    input logic             mask_i,
    input logic             mask_ui,
    input logic [N_IRQ-1:0] irq_clr
);
    localparam int MOD_BASE = 2 + N_IRQ;

    assert_take_masks_R9: assert property (@(posedge clk) disable iff (rst)
        (ack && req_valid) |=> (mask_i && mask_ui && !req_valid));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !ack) |=> (req_valid && $stable(req_vec)));

    assert_clr_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_clr));

    assert_clr_cause_R11: assert property (@(posedge clk) disable iff (rst)
        (irq_clr != '0) |-> $past(ack && req_valid));

    assert_ack_wins_R12: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && ack && req_valid) |=> (mask_i && mask_ui));

    assert_wr_loads_R13: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !(ack && req_valid)) |=>
            (mask_i == $past(stat_i) && mask_ui == $past(stat_ui)));

    assert_mod_masked_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(req_valid) && req_vec >= VW'(MOD_BASE)) |-> !$past(mask_i));
endmodule

bind irq_prioritizer irqp_chk #(.N_IRQ(N_IRQ), .VW(VW)) u_chk (
    .clk(clk), .rst(rst), .ack(ack), .stat_wr(stat_wr),
    .stat_i(stat_i), .stat_ui(stat_ui), .req_valid(req_valid),
    .req_vec(req_vec), .mask_i(mask_i), .mask_ui(mask_ui),
    .irq_clr(irq_clr)
);

// File: tb/irq_prioritizer_bench.sv
`timescale 1ns/1ps
module irq_prioritizer_bench;
    localparam int NI = 4;
    localparam int NM = 2;
    localparam int VWB = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NI-1:0] irq_req = '0, irq_en = '0, irq_lvl = '0;
    logic [NM-1:0] mod_req = '0, mod_en = '0;
    logic brk_req = 0, nmi_in = 0, ack = 0, stat_wr = 0, stat_i = 0, stat_ui = 0;
    logic req_valid, mask_i, mask_ui;
    logic [VWB-1:0] req_vec;
    logic [NI-1:0] irq_clr;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    irq_prioritizer #(.N_IRQ(NI), .N_MOD(NM)) u_irq_prioritizer (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_en(irq_en),
        .irq_lvl(irq_lvl), .mod_req(mod_req), .mod_en(mod_en),
        .brk_req(brk_req), .nmi_in(nmi_in), .ack(ack),
        .stat_wr(stat_wr), .stat_i(stat_i), .stat_ui(stat_ui),
        .req_valid(req_valid), .req_vec(req_vec), .mask_i(mask_i),
        .mask_ui(mask_ui), .irq_clr(irq_clr)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Reference winner per R2-R6; -1 means nothing presented.
    function automatic int ref_vec(input logic nmi, input logic brk,
                                   input logic [NI-1:0] ia, input logic [NI-1:0] lv,
                                   input logic [NM-1:0] ma, input logic mi, input logic mu);
        if (nmi) return 0;
        for (int k = 0; k < NI; k++) if (ia[k] && lv[k] && !(mi && mu)) return 2 + k;
        if (brk) return 1;
        for (int k = 0; k < NI; k++) if (ia[k] && !lv[k] && !mi) return 2 + k;
        for (int j = 0; j < NM; j++) if (ma[j] && !mi) return 2 + NI + j;
        return -1;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1; ack = 0; stat_wr = 0; irq_req = '0; mod_req = '0;
        brk_req = 0; nmi_in = 0;
        @(negedge clk);
        check("R1 valid", int'(req_valid), 0);
        check("R1 mask_i", int'(mask_i), 1);
        check("R1 mask_ui", int'(mask_ui), 0);
        check("R1 clr", int'(irq_clr), 0);
        rst = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // Sweep: R2 R3 R4 R5 R6 R7 R9 R10 R11 R12 R13
        for (int it = 0; it < 600; it++) begin
            int e;
            int e2;
            logic mi, mu, both;
            do_reset();
            seed = nxt(seed);
            irq_req = seed[3:0];   irq_en = seed[7:4];   irq_lvl = seed[11:8];
            mod_req = seed[13:12]; mod_en = seed[15:14];
            brk_req = seed[16] & seed[17];
            nmi_in  = seed[18] & seed[19] & seed[20];
            mi = seed[21]; mu = seed[22]; both = seed[23];
            stat_wr = 1; stat_i = mi; stat_ui = mu;
            @(posedge clk);
            @(negedge clk);
            stat_wr = 0;
            check("R13 mask_i", int'(mask_i), int'(mi));
            check("R13 mask_ui", int'(mask_ui), int'(mu));
            check("R7 no early valid", int'(req_valid), 0);
            @(posedge clk);
            #1;
            e = ref_vec(nmi_in, brk_req, irq_req & irq_en, irq_lvl,
                        mod_req & mod_en, mi, mu);
            check("R2 R3 R4 R5 valid", int'(req_valid), int'(e >= 0));
            if (e >= 0) check("R6 vector", int'(req_vec), e);
            @(negedge clk);
            if (req_valid) begin
                ack = 1;
                stat_wr = both; stat_i = 0; stat_ui = 0;
                @(posedge clk);
                #1;
                ack = 0; stat_wr = 0;
                check("R9 valid drop", int'(req_valid), 0);
                check("R9 R12 mask_i", int'(mask_i), 1);
                check("R9 R12 mask_ui", int'(mask_ui), 1);
                check("R11 clr", int'(irq_clr),
                      (e >= 2 && e < 2 + NI) ? (1 << (e - 2)) : 0);
                @(posedge clk);
                #1;
                check("R11 clr one cycle", int'(irq_clr), 0);
                // NMI held high does not re-pend; only brk is open now.
                e2 = ref_vec((e != 0) && nmi_in, brk_req, irq_req & irq_en,
                             irq_lvl, mod_req & mod_en, 1'b1, 1'b1);
                check("R4 R10 re-arb valid", int'(req_valid), int'(e2 >= 0));
                if (e2 >= 0) check("R4 R10 re-arb vector", int'(req_vec), e2);
            end else begin
                ack = 1;
                @(posedge clk);
                #1;
                ack = 0;
                check("R9 ack ignored mask_i", int'(mask_i), int'(mi));
                check("R9 ack ignored mask_ui", int'(mask_ui), int'(mu));
            end
        end

        // Directed R8 and R10: hold against a later NMI edge.
        do_reset();
        irq_req = 4'b0001; irq_en = 4'b1111; irq_lvl = 4'b0000;
        stat_wr = 1; stat_i = 0; stat_ui = 0;
        @(negedge clk);
        stat_wr = 0;
        @(negedge clk);
        check("R8 first winner", int'(req_vec), 2);
        nmi_in = 1;
        repeat (3) @(negedge clk);
        check("R8 hold valid", int'(req_valid), 1);
        check("R8 hold vector", int'(req_vec), 2);
        ack = 1;
        @(negedge clk);
        ack = 0;
        @(negedge clk);
        check("R10 nmi pending", int'(req_valid), 1);
        check("R10 nmi vector", int'(req_vec), 0);
        ack = 1;
        @(negedge clk);
        ack = 0;
        repeat (3) @(negedge clk);
        check("R10 no re-pend on level", int'(req_valid), 0);
        // Level-1 IRQ re-opened by clearing UI only (R3).
        irq_lvl = 4'b0001;
        stat_wr = 1; stat_i = 1; stat_ui = 0;
        @(negedge clk);
        stat_wr = 0;
        @(negedge clk);
        check("R3 level1 open with UI clear", int'(req_vec), 2);
        check("R3 level1 valid", int'(req_valid), 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule